// File: doc/BRIEF.md
# Byte ALU with Masked Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it takes two byte operands and an operation code, and it produces a byte result combinationally. On the clock edge it merges that operation's flags into an 8-bit status register. Every operation owns a fixed subset of flags and writes only that subset. All other status bits keep their value, so a chain of instructions can carry conditions from one to the next. The add-with-carry and subtract-with-borrow operations read the carry they need from the status register. Subtract-with-borrow also reads the zero flag, which makes multi-byte compares work.

Two operation groups take two clocks. The word add and word subtract combine a 16-bit register pair with a 6-bit unsigned immediate. The three multiplies (unsigned, signed, and signed by unsigned) form a 16-bit product. For these operations the block raises `busy_o` for one cycle. At the end of that cycle it registers the 16-bit result and updates the flags. While `busy_o` is high the block accepts no new operation. The surrounding core can load the status register directly, and that load overrides any flag update on the same edge.

Top module: `byte_alu`

## Requirements
- R1: After reset `sreg_o`, `wide_o` and `busy_o` are zero. The status bit layout is 7=I, 6=T, 5=H, 4=S, 3=V, 2=N, 1=Z, 0=C. No operation ever changes I or T.
- R2: The `op_i` codes are 0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4 and, 5 or, 6 xor, 7 invert, 8 negate, 9 increment, 10 decrement, 11 test, 12 clear, 13 set-all, 14 word add, 15 word sub, 16 unsigned mul, 17 signed mul and 18 signed-by-unsigned mul. Codes 19 to 31 are undefined. Add and add-with-carry give `a_i+b_i(+C)` and write H (carry out of bit 3), C (carry out of bit 7), V (signed overflow), N (bit 7), Z (result zero) and S = N xor V.
- R3: Sub and sub-with-borrow give `a_i-b_i(-C)`, and negate gives `0-a_i`. All three write H and C as borrows, plus V, N, Z and S. For sub-with-borrow, Z is cleared when the result is nonzero and is otherwise left unchanged.
- R4: And, or, xor, test (result `a_i`) and clear (result 0) write only Z, N, S and V, and they force V to 0. Increment and decrement write the same four flags. Increment sets V when the result is 0x80, and decrement sets V when the result is 0x7F. H and C are unchanged.
- R5: Invert gives `~a_i`, sets C to 1, clears V and writes Z, N and S. H is unchanged.
- R6: Set-all gives 0xFF and leaves `sreg_o` unchanged.
- R7: Word add and word sub give `word_i ± b_i[5:0]` (immediate zero-extended) on `wide_o`. They write Z, C, N, V and S from the 16-bit result and leave H unchanged.
- R8: The three multiplies give the low 16 bits of the product on `wide_o`. They write only C (product bit 15) and Z (product zero).
- R9: When an operation with code 14 to 18 is accepted, `busy_o` is high for exactly the next cycle. `wide_o` and the flags update at the end of that cycle. `op_valid_i` is ignored while `busy_o` is high.
- R10: When `sreg_we_i` is high, `sreg_o` takes `sreg_d_i` at the next edge, overriding any flag update on that edge.
- R11: Undefined codes give result 0 and leave `sreg_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand or immediate |
| word_i | input | 16 | Register pair for word operations |
| sreg_we_i | input | 1 | Direct status register load |
| sreg_d_i | input | 8 | Status load value |
| result_o | output | 8 | Byte result (combinational) |
| wide_o | output | 16 | Registered word or product result |
| busy_o | output | 1 | Second cycle of a two-clock operation |
| sreg_o | output | 8 | Status register |

## Verification
Two functions can land on the same edge. One is a direct status load. The other is a flag update, either from a byte operation issued in that cycle or from a word or multiply operation completing its second cycle. The bench raises `sreg_we_i` at random alongside both kinds of update. The check passes only if `sreg_o` then equals the loaded value. A further case issues a new multiply during the busy cycle; after completion `busy_o` must be low again, which shows that the second request was dropped.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDC = 5'd1,  OP_SUB  = 5'd2,  OP_SUBC  = 5'd3,
    OP_AND   = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_INV   = 5'd7,
    OP_NEG   = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_TST   = 5'd11,
    OP_CLR   = 5'd12, OP_SET  = 5'd13, OP_WADD = 5'd14, OP_WSUB  = 5'd15,
    OP_MULU  = 5'd16, OP_MULS = 5'd17, OP_MULSU = 5'd18
  } alu_op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  localparam logic [7:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [7:0] MASK_LOGIC = 8'b0001_1110;
  localparam logic [7:0] MASK_INV   = 8'b0001_1111;
  localparam logic [7:0] MASK_WORD  = 8'b0001_1111;
  localparam logic [7:0] MASK_MUL   = 8'b0000_0011;

  function automatic logic is_two_clk(alu_op_e op);
    return op inside {OP_WADD, OP_WSUB, OP_MULU, OP_MULS, OP_MULSU};
  endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic            c_i,
  input  logic            z_i,
  output logic [DW-1:0]   res_o,
  output logic [7:0]      flags_o,
  output logic [7:0]      mask_o
);
  localparam int MSB = DW - 1;
  localparam int NB  = DW / 2;  // half-carry bit position

  logic [DW:0]   ext;
  logic [DW-1:0] x, y, r;
  logic          cin, co, hc, vf, zf;

  always_comb begin
    x      = a_i;
    y      = b_i;
    cin    = 1'b0;
    ext    = '0;
    r      = '0;
    co     = 1'b0;
    hc     = 1'b0;
    vf     = 1'b0;
    mask_o = '0;
    case (op_i)
      OP_ADD, OP_ADDC: begin
        cin    = (op_i == OP_ADDC) & c_i;
        ext    = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
        r      = ext[MSB:0];
        co     = ext[DW];
        hc     = x[NB] ^ y[NB] ^ r[NB];
        vf     = (x[MSB] == y[MSB]) && (r[MSB] != x[MSB]);
        mask_o = MASK_ARITH;
      end
      OP_SUB, OP_SUBC, OP_NEG: begin
        if (op_i == OP_NEG) begin
          x = '0;
          y = a_i;
        end
        cin    = (op_i == OP_SUBC) & c_i;
        ext    = {1'b0, x} - {1'b0, y} - {{DW{1'b0}}, cin};
        r      = ext[MSB:0];
        co     = ext[DW];
        hc     = x[NB] ^ y[NB] ^ r[NB];
        vf     = (x[MSB] != y[MSB]) && (r[MSB] != x[MSB]);
        mask_o = MASK_ARITH;
      end
      OP_AND: begin r = a_i & b_i; mask_o = MASK_LOGIC; end
      OP_OR:  begin r = a_i | b_i; mask_o = MASK_LOGIC; end
      OP_XOR: begin r = a_i ^ b_i; mask_o = MASK_LOGIC; end
      OP_TST: begin r = a_i;       mask_o = MASK_LOGIC; end
      OP_CLR: begin r = '0;        mask_o = MASK_LOGIC; end
      OP_INV: begin
        r      = ~a_i;
        co     = 1'b1;
        mask_o = MASK_INV;
      end
      OP_INC: begin
        r      = a_i + 1'b1;
        vf     = (r == {1'b1, {(DW-1){1'b0}}});
        mask_o = MASK_LOGIC;
      end
      OP_DEC: begin
        r      = a_i - 1'b1;
        vf     = (r == {1'b0, {(DW-1){1'b1}}});
        mask_o = MASK_LOGIC;
      end
      OP_SET: r = '1;
      default: r = '0;
    endcase
    // borrow chain: a zero result keeps the previous Z
    zf = (r == '0) && !((op_i == OP_SUBC) && !z_i);
    flags_o       = '0;
    flags_o[FL_C] = co;
    flags_o[FL_Z] = zf;
    flags_o[FL_N] = r[MSB];
    flags_o[FL_V] = vf;
    flags_o[FL_S] = r[MSB] ^ vf;
    flags_o[FL_H] = hc;
    res_o         = r;
  end
endmodule

// File: rtl/alu_wide.sv
module alu_wide
  import alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  alu_op_e         op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [2*DW-1:0] word_i,
  output logic            busy_o,
  output logic [2*DW-1:0] wide_o,
  output logic [7:0]      flags_o,
  output logic [7:0]      mask_o
);
  localparam int WW  = 2 * DW;
  localparam int WMS = WW - 1;

  logic          busy_q;
  alu_op_e       op_q;
  logic [DW-1:0] a_q, b_q;
  logic [WW-1:0] w_q, wide_q, k, ea, eb, r;
  logic          cf, vf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_ADD;
      a_q    <= '0;
      b_q    <= '0;
      w_q    <= '0;
    end else begin
      busy_q <= start_i;
      if (start_i) begin
        op_q <= op_i;
        a_q  <= a_i;
        b_q  <= b_i;
        w_q  <= word_i;
      end
    end
  end

  always_comb begin
    k      = {{(WW-IW){1'b0}}, b_q[IW-1:0]};
    ea     = (op_q == OP_MULU) ? {{DW{1'b0}}, a_q} : {{DW{a_q[DW-1]}}, a_q};
    eb     = (op_q == OP_MULS) ? {{DW{b_q[DW-1]}}, b_q} : {{DW{1'b0}}, b_q};
    r      = '0;
    cf     = 1'b0;
    vf     = 1'b0;
    mask_o = MASK_MUL;
    case (op_q)
      OP_WADD: begin
        r      = w_q + k;
        vf     = !w_q[WMS] && r[WMS];
        cf     = w_q[WMS] && !r[WMS];
        mask_o = MASK_WORD;
      end
      OP_WSUB: begin
        r      = w_q - k;
        vf     = w_q[WMS] && !r[WMS];
        cf     = !w_q[WMS] && r[WMS];
        mask_o = MASK_WORD;
      end
      default: begin
        r  = ea * eb;  // low half is exact for either signedness
        cf = r[WMS];
      end
    endcase
    flags_o       = '0;
    flags_o[FL_C] = cf;
    flags_o[FL_Z] = (r == '0);
    flags_o[FL_N] = r[WMS];
    flags_o[FL_V] = vf;
    flags_o[FL_S] = r[WMS] ^ vf;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wide_q <= '0;
    else if (busy_q) wide_q <= r;
  end

  assign busy_o = busy_q;
  assign wide_o = wide_q;
endmodule

// File: rtl/alu_sreg.sv
module alu_sreg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] d_i,
  input  logic       upd_i,
  input  logic [7:0] flags_i,
  input  logic [7:0] mask_i,
  output logic [7:0] q_o
);
  logic [7:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q <= '0;
    else if (we_i)  q <= d_i;
    else if (upd_i) q <= (q & ~mask_i) | (flags_i & mask_i);
  end

  assign q_o = q;
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import alu_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [4:0]      op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  input  logic [2*DW-1:0] word_i,
  input  logic            sreg_we_i,
  input  logic [7:0]      sreg_d_i,
  output logic [DW-1:0]   result_o,
  output logic [2*DW-1:0] wide_o,
  output logic            busy_o,
  output logic [7:0]      sreg_o
);
  alu_op_e    op;
  logic       accept, core_upd, wide_start, wide_busy;
  logic [7:0] core_flags, core_mask, wide_flags, wide_mask, sel_flags, sel_mask;

  assign op         = alu_op_e'(op_i);
  assign accept     = op_valid_i && !wide_busy;
  assign core_upd   = accept && !is_two_clk(op);
  assign wide_start = accept && is_two_clk(op);

  alu_core #(.DW(DW)) u_core (
    .op_i   (op),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (sreg_o[FL_C]),
    .z_i    (sreg_o[FL_Z]),
    .res_o  (result_o),
    .flags_o(core_flags),
    .mask_o (core_mask)
  );

  alu_wide #(.DW(DW), .IW(IW)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wide_start),
    .op_i   (op),
    .a_i    (a_i),
    .b_i    (b_i),
    .word_i (word_i),
    .busy_o (wide_busy),
    .wide_o (wide_o),
    .flags_o(wide_flags),
    .mask_o (wide_mask)
  );

  // no byte op is accepted while busy, so the two sources never collide
  assign sel_flags = wide_busy ? wide_flags : core_flags;
  assign sel_mask  = wide_busy ? wide_mask  : core_mask;

  alu_sreg u_sreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (sreg_we_i),
    .d_i    (sreg_d_i),
    .upd_i  (core_upd || wide_busy),
    .flags_i(sel_flags),
    .mask_i (sel_mask),
    .q_o    (sreg_o)
  );

  assign busy_o = wide_busy;
endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk
  import alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_valid_i,
  input logic [4:0]      op_i,
  input logic            sreg_we_i,
  input logic [7:0]      sreg_d_i,
  input logic [2*DW-1:0] wide_o,
  input logic            busy_o,
  input logic [7:0]      sreg_o
);
  alu_op_e op;
  logic    acc, mul_q;

  assign op  = alu_op_e'(op_i);
  assign acc = op_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  mul_q <= 1'b0;
    else if (acc) mul_q <= op inside {OP_MULU, OP_MULS, OP_MULSU};
  end

  AST_IT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sreg_we_i |=> sreg_o[7:6] == $past(sreg_o[7:6])); // R1

  AST_LOGIC_V_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !sreg_we_i && (op inside {OP_AND, OP_OR, OP_XOR, OP_TST, OP_CLR})
    |=> !sreg_o[FL_V]); // R4

  AST_SIGN_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !sreg_we_i && (op inside {[OP_ADD:OP_CLR]})
    |=> sreg_o[FL_S] == (sreg_o[FL_N] ^ sreg_o[FL_V])); // R4

  AST_INV_C_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !sreg_we_i && op == OP_INV |=> sreg_o[FL_C]); // R5

  AST_SET_NO_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !sreg_we_i && op == OP_SET |=> $stable(sreg_o)); // R6

  AST_MUL_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && mul_q && !sreg_we_i
    |=> sreg_o[FL_C] == wide_o[2*DW-1] && sreg_o[FL_Z] == (wide_o == '0)); // R8

  AST_BUSY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o); // R9

  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && is_two_clk(op) |=> busy_o); // R9

  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sreg_we_i |=> sreg_o == $past(sreg_d_i)); // R10
endmodule

bind byte_alu byte_alu_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_valid_i(op_valid_i),
  .op_i      (op_i),
  .sreg_we_i (sreg_we_i),
  .sreg_d_i  (sreg_d_i),
  .wide_o    (wide_o),
  .busy_o    (busy_o),
  .sreg_o    (sreg_o)
);

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  a = '0, b = '0, sreg_d = '0;
  logic [15:0] word = '0;
  logic        sreg_we = 1'b0;
  logic [7:0]  result, sreg;
  logic [15:0] wide;
  logic        busy;

  int   n_checks = 0, n_fail = 0;
  bit   done = 0;
  logic [7:0] m_sreg = '0;

  always #2.5 clk = ~clk;

  byte_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op),
    .a_i(a), .b_i(b), .word_i(word), .sreg_we_i(sreg_we), .sreg_d_i(sreg_d),
    .result_o(result), .wide_o(wide), .busy_o(busy), .sreg_o(sreg)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      OP_ADD, OP_ADDC:                         return "R2";
      OP_SUB, OP_SUBC, OP_NEG:                 return "R3";
      OP_AND, OP_OR, OP_XOR, OP_TST, OP_CLR,
      OP_INC, OP_DEC:                          return "R4";
      OP_INV:                                  return "R5";
      OP_SET:                                  return "R6";
      OP_WADD, OP_WSUB:                        return "R7";
      OP_MULU, OP_MULS, OP_MULSU:              return "R8";
      default:                                 return "R11";
    endcase
  endfunction

  function automatic void ref8(input logic [4:0] o, input logic [7:0] x, y, s,
                               output logic [7:0] r, output logic [7:0] ns);
    int ux, uy, sx, sy, t, ci;
    logic h, v, c;
    bit wh, wc, wz;
    ns = s; r = '0; h = 0; v = 0; c = 0; wh = 0; wc = 0; wz = 0;
    ci = int'(s[0]);
    ux = int'(x); uy = int'(y);
    sx = int'($signed(x)); sy = int'($signed(y));
    case (o)
      OP_ADD, OP_ADDC: begin
        if (o == OP_ADD) ci = 0;
        t = ux + uy + ci; r = t[7:0];
        c = (t > 255); h = ((ux % 16) + (uy % 16) + ci) > 15;
        v = (sx + sy + ci > 127) || (sx + sy + ci < -128);
        wh = 1; wc = 1; wz = 1;
      end
      OP_SUB, OP_SUBC, OP_NEG: begin
        if (o != OP_SUBC) ci = 0;
        if (o == OP_NEG) begin ux = 0; uy = int'(x); sx = 0; sy = int'($signed(x)); end
        t = ux - uy - ci; r = t[7:0];
        c = (t < 0); h = (ux % 16) < ((uy % 16) + ci);
        v = (sx - sy - ci > 127) || (sx - sy - ci < -128);
        wh = 1; wc = 1; wz = 1;
      end
      OP_AND: begin r = x & y; wz = 1; end
      OP_OR:  begin r = x | y; wz = 1; end
      OP_XOR: begin r = x ^ y; wz = 1; end
      OP_TST: begin r = x;     wz = 1; end
      OP_CLR: begin r = 8'h00; wz = 1; end
      OP_INV: begin r = 8'hFF - x; c = 1; wc = 1; wz = 1; end
      OP_INC: begin r = x + 8'd1; v = (x == 8'h7F); wz = 1; end
      OP_DEC: begin r = x - 8'd1; v = (x == 8'h80); wz = 1; end
      OP_SET: r = 8'hFF;
      default: r = 8'h00;
    endcase
    if (wz) begin
      if (o == OP_SUBC) ns[1] = (r == 8'h00) ? s[1] : 1'b0;
      else              ns[1] = (r == 8'h00);
      ns[2] = r[7]; ns[3] = v; ns[4] = r[7] ^ v;
    end
    if (wc) ns[0] = c;
    if (wh) ns[5] = h;
  endfunction

  function automatic void ref16(input logic [4:0] o, input logic [7:0] x, y,
                                input logic [15:0] w, input logic [7:0] s,
                                output logic [15:0] r, output logic [7:0] ns);
    int t, k;
    logic v, c;
    ns = s; v = 0; c = 0;
    k = int'(y[5:0]);
    case (o)
      OP_WADD: begin t = int'(w) + k; c = (t > 65535); v = (int'($signed(w)) + k > 32767); end
      OP_WSUB: begin t = int'(w) - k; c = (t < 0);     v = (int'($signed(w)) - k < -32768); end
      OP_MULU: t = int'(x) * int'(y);
      OP_MULS: t = int'($signed(x)) * int'($signed(y));
      default: t = int'($signed(x)) * int'(y);
    endcase
    r = t[15:0];
    if (o == OP_WADD || o == OP_WSUB) begin
      ns[0] = c; ns[1] = (r == 16'h0); ns[2] = r[15]; ns[3] = v; ns[4] = r[15] ^ v;
    end else begin
      ns[0] = r[15]; ns[1] = (r == 16'h0);
    end
  endfunction

  // called just after a rising edge
  task automatic run_single(input logic [4:0] o, input logic [7:0] xa, xb,
                            input logic we, input logic [7:0] d);
    logic [7:0] er, es;
    ref8(o, xa, xb, m_sreg, er, es);
    op_valid = 1; op = o; a = xa; b = xb; sreg_we = we; sreg_d = d;
    @(negedge clk);
    chk({tag_of(o), " result"}, {8'h00, result}, {8'h00, er});
    @(posedge clk); #1;
    op_valid = 0; sreg_we = 0;
    if (we) es = d;
    chk(we ? "R10 load wins" : {tag_of(o), " flags"}, {8'h00, sreg}, {8'h00, es});
    m_sreg = es;
  endtask

  task automatic run_wide(input logic [4:0] o, input logic [7:0] xa, xb,
                          input logic [15:0] w, input logic we, input logic [7:0] d,
                          input logic poke);
    logic [15:0] er;
    logic [7:0]  es;
    ref16(o, xa, xb, w, m_sreg, er, es);
    op_valid = 1; op = o; a = xa; b = xb; word = w;
    @(posedge clk); #1;
    chk("R9 busy high", {15'h0, busy}, 16'h1);
    op_valid = poke; op = OP_MULU; a = 8'hFF; b = 8'hFF; sreg_we = we; sreg_d = d;
    @(posedge clk); #1;
    op_valid = 0; sreg_we = 0;
    chk("R9 busy drops, request during busy ignored", {15'h0, busy}, 16'h0);
    chk({tag_of(o), " wide"}, wide, er);
    if (we) es = d;
    chk(we ? "R10 load wins over completion" : {tag_of(o), " flags"}, {8'h00, sreg}, {8'h00, es});
    m_sreg = es;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1F));
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 sreg reset", {8'h00, sreg}, 16'h0);
    chk("R1 wide reset", wide, 16'h0);
    chk("R1 busy reset", {15'h0, busy}, 16'h0);

    // directed corners
    run_single(OP_SET, 0, 0, 1, 8'hC0);      // preset I,T via load (R10)
    run_single(OP_ADD, 8'h7F, 8'h01, 0, 0);  // R2 V,H,N
    run_single(OP_ADD, 8'hFF, 8'h01, 0, 0);  // R2 C,Z,H
    run_single(OP_ADDC, 8'h10, 8'h20, 0, 0); // R2 carry in
    run_single(OP_SUB, 8'h80, 8'h01, 0, 0);  // R3 V
    run_single(OP_SET, 0, 0, 1, 8'h02);      // Z=1,C=0
    run_single(OP_SUBC, 8'h05, 8'h05, 0, 0); // R3 zero keeps Z=1
    run_single(OP_SET, 0, 0, 1, 8'h00);
    run_single(OP_SUBC, 8'h05, 8'h05, 0, 0); // R3 zero keeps Z=0
    run_single(OP_SUBC, 8'h05, 8'h06, 0, 0); // R3 borrow
    run_single(OP_SUBC, 8'h05, 8'h04, 0, 0); // R3 consumes borrow
    run_single(OP_NEG, 8'h80, 0, 0, 0);      // R3
    run_single(OP_NEG, 8'h00, 0, 0, 0);      // R3
    run_single(OP_INC, 8'h7F, 0, 0, 0);      // R4
    run_single(OP_DEC, 8'h80, 0, 0, 0);      // R4
    run_single(OP_AND, 8'hF0, 8'h0F, 0, 0);  // R4
    run_single(OP_CLR, 8'h55, 0, 0, 0);      // R4
    run_single(OP_INV, 8'hFF, 0, 0, 0);      // R5
    run_single(OP_SET, 8'h12, 8'h34, 0, 0);  // R6
    run_single(5'd25, 8'h12, 8'h34, 0, 0);   // R11
    run_wide(OP_WADD, 0, 8'h01, 16'hFFFF, 0, 0, 0); // R7
    run_wide(OP_WADD, 0, 8'h3F, 16'h7FF0, 0, 0, 0); // R7
    run_wide(OP_WSUB, 0, 8'h01, 16'h0000, 0, 0, 0); // R7
    run_wide(OP_WSUB, 0, 8'hC1, 16'h8000, 0, 0, 1); // R7 imm bits above 6 unused
    run_wide(OP_MULS, 8'h80, 8'h80, 0, 0, 0, 0);    // R8
    run_wide(OP_MULSU, 8'hFF, 8'hFF, 0, 0, 0, 0);   // R8
    run_wide(OP_MULU, 8'h00, 8'h9A, 0, 0, 0, 1);    // R8
    run_wide(OP_MULU, 8'hFF, 8'hFF, 0, 1, 8'h5A, 0);// R10

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] o;
      logic we;
      o  = 5'($urandom_range(0, 21));
      we = ($urandom_range(0, 7) == 0);
      if (o >= OP_WADD && o <= OP_MULSU)
        run_wide(o, 8'($urandom), 8'($urandom), 16'($urandom), we, 8'($urandom),
                 1'($urandom_range(0, 1)));
      else
        run_single(o, 8'($urandom), 8'($urandom), we, 8'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule